// File: doc/BRIEF.md
# Timed Challenge Admin Authenticator

This block controls entry into administrator enrollment on a multi-user lock. A dedicated mode key moves the block from idle into admin mode, and the admin indicator lights. The operator puts a delay in whole seconds on a 4-bit parallel input. The operator then presses the authentication key twice. The first press captures the delay and starts a count of 50 ms ticks. The second press stops the count, and the count is compared with the requested delay.

If the measured time lies inside the acceptance window, the block opens an enrollment window. In that window exactly one user record, made of an ID, a bit pattern and a set of interval values, passes to the user-table write port. After that single write the block goes back to idle. A zero delay, a second press outside the window, or a missing second press all produce a one-cycle error pulse and a return to idle. The user table itself and key debouncing are outside this block. All key inputs are one-cycle pulses that have already been cleaned up.

Top module: `admin_timed_auth`

## Requirements
- R1: After reset, admin_led, grant, err and wr_en are all 0 and the block is idle.
- R2: An admin_key pulse while idle puts the block in admin mode. admin_led is 1 from the next cycle and stays 1 until the block returns to idle.
- R3: The first auth_key pulse in admin mode latches wait_sec. If wait_sec is 0, err pulses on the next cycle and the block returns to idle, with admin_led at 0.
- R4: Time is measured in ticks of TICK_CYCLES clocks. The target is wait_sec × 20 ticks, so a delay of 2 needs 30 to 50 ticks, and 29 ticks is rejected.
- R5: A second auth_key pulse with an elapsed tick count in [target−10, target+10] raises grant on the next cycle.
- R6: A second auth_key pulse outside that window gives a one-cycle err pulse and a return to idle, with no grant.
- R7: If no second press arrives before the elapsed count passes target+10, err pulses and the block returns to idle. This happens one clock after the count first exceeds the limit.
- R8: While grant is 1, an enroll_valid pulse raises wr_en for one cycle on the next cycle. At the same time, wr_id, wr_pattern and wr_intervals carry that cycle's enroll_id, enroll_pattern and enroll_intervals, and grant and admin_led fall.
- R9: enroll_valid has no effect when grant is 0. This includes a second attempt after a completed write.
- R10: err and wr_en are single-cycle pulses.
- R11: admin_key has no effect outside idle. auth_key has no effect while idle or while grant is 1.
- R12: A change of wait_sec after the first press does not affect the target of the running challenge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| admin_key | input | 1 | Pulse: request admin mode |
| auth_key | input | 1 | Pulse: authentication key press |
| wait_sec | input | WAIT_W | Requested delay in seconds |
| enroll_valid | input | 1 | Pulse: user record offered for enrollment |
| enroll_id | input | ID_W | User ID of the offered record |
| enroll_pattern | input | PAT_W | Bit pattern of the offered record |
| enroll_intervals | input | NUM_INTV*INTV_W | Packed interval values of the offered record |
| admin_led | output | 1 | Admin mode active |
| grant | output | 1 | Enrollment window open |
| err | output | 1 | One-cycle error pulse |
| wr_en | output | 1 | One-cycle user-table write strobe |
| wr_id | output | ID_W | Record ID for the write |
| wr_pattern | output | PAT_W | Record pattern for the write |
| wr_intervals | output | NUM_INTV*INTV_W | Record intervals for the write |

## Verification
Every decision is registered once. admin_led, grant, err and wr_en therefore change one clock after the edge that samples the causing pulse. The elapsed count seen by a second press k edges after the first is floor((k−1)/TICK_CYCLES). The bench places presses at k = n·TICK_CYCLES+1 so the count is exactly n. A timeout error is due at edge (target+11)·TICK_CYCLES+1 after the first press, and the bench checks that err is still 0 one cycle before that edge. Inputs are driven and outputs sampled on the falling edge, so each check reads the value the last rising edge produced.

// File: rtl/ata_pkg.sv
package ata_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_TIMING = 2'd2,
    ST_GRANT  = 2'd3
  } ata_state_e;
endpackage

// File: rtl/ata_rst_sync.sv
module ata_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ata_tick_gen.sv
module ata_tick_gen #(
  parameter int TICK_CYCLES = 12_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int PRESC_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PRESC_W-1:0] LAST = PRESC_W'(TICK_CYCLES - 1);

  logic [PRESC_W-1:0] presc_q, presc_d;

  assign tick_o = run_i && (presc_q == LAST);

  always_comb begin
    presc_d = presc_q;
    if (clear_i)     presc_d = '0;
    else if (tick_o) presc_d = '0;
    else if (run_i)  presc_d = presc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) presc_q <= '0;
    else        presc_q <= presc_d;
  end

  // R4: prescaler never passes the tick period
  assert_presc_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    presc_q <= LAST);
  // R4: a tick restarts the prescaler period
  assert_tick_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !clear_i) |=> (presc_q == '0));
endmodule

// File: rtl/ata_elapsed.sv
module ata_elapsed #(
  parameter int WAIT_W        = 4,
  parameter int TICKS_PER_SEC = 20,
  parameter int TOL_TICKS     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic              in_window_o,
  output logic              overrun_o
);
  localparam int MAX_TARGET = ((1 << WAIT_W) - 1) * TICKS_PER_SEC;
  localparam int CNT_W      = $clog2(MAX_TARGET + TOL_TICKS + 2);
  localparam logic [CNT_W-1:0] TPS_C = CNT_W'(TICKS_PER_SEC);
  localparam logic [CNT_W-1:0] TOL_C = CNT_W'(TOL_TICKS);

  logic [WAIT_W-1:0] wait_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  target, win_lo, win_hi;

  assign target = CNT_W'(wait_q) * TPS_C;
  assign win_lo = (target > TOL_C) ? (target - TOL_C) : '0;
  assign win_hi = target + TOL_C;

  assign in_window_o = (cnt_q >= win_lo) && (cnt_q <= win_hi);
  assign overrun_o   = cnt_q > win_hi;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)                        cnt_d = '0;
    else if (tick_i && (cnt_q != '1))   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= '0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (clear_i) wait_q <= wait_i;
    end
  end

  // R12: latched delay holds for the whole measurement
  assert_wait_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !clear_i) |=> $stable(wait_q));
  // R7: the count cannot run more than one tick past the limit while timing
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= win_hi + 1'b1));
endmodule

// File: rtl/ata_enroll_gate.sv
module ata_enroll_gate #(
  parameter int ID_W  = 4,
  parameter int PAT_W = 4,
  parameter int REC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  logic [ID_W-1:0]  id_i,
  input  logic [PAT_W-1:0] pat_i,
  input  logic [REC_W-1:0] intv_i,
  output logic             wr_en_o,
  output logic [ID_W-1:0]  wr_id_o,
  output logic [PAT_W-1:0] wr_pat_o,
  output logic [REC_W-1:0] wr_intv_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_o   <= 1'b0;
      wr_id_o   <= '0;
      wr_pat_o  <= '0;
      wr_intv_o <= '0;
    end else begin
      wr_en_o <= fire_i;
      if (fire_i) begin
        wr_id_o   <= id_i;
        wr_pat_o  <= pat_i;
        wr_intv_o <= intv_i;
      end
    end
  end

  // R10: write strobe lasts one cycle
  assert_wr_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o);
endmodule

// File: rtl/ata_ctrl.sv
module ata_ctrl
  import ata_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       admin_key_i,
  input  logic       auth_key_i,
  input  logic       wait_zero_i,
  input  logic       in_window_i,
  input  logic       overrun_i,
  input  logic       enroll_valid_i,
  output ata_state_e state_o,
  output logic       start_o,
  output logic       run_o,
  output logic       err_o,
  output logic       fire_o
);
  ata_state_e state_q, state_d;
  logic       err_d;

  always_comb begin
    state_d = state_q;
    err_d   = 1'b0;
    start_o = 1'b0;
    fire_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (admin_key_i) state_d = ST_ARMED;
      end
      ST_ARMED: begin
        if (auth_key_i) begin
          if (wait_zero_i) begin
            state_d = ST_IDLE;
            err_d   = 1'b1;
          end else begin
            state_d = ST_TIMING;
            start_o = 1'b1;
          end
        end
      end
      ST_TIMING: begin
        if (auth_key_i) begin
          if (in_window_i) state_d = ST_GRANT;
          else begin
            state_d = ST_IDLE;
            err_d   = 1'b1;
          end
        end else if (overrun_i) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end
      end
      ST_GRANT: begin
        if (enroll_valid_i) begin
          state_d = ST_IDLE;
          fire_o  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_o   <= err_d;
    end
  end

  assign state_o = state_q;
  assign run_o   = (state_q == ST_TIMING);

  // R2: mode key from idle arms the challenge
  assert_enter_admin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && admin_key_i) |=> (state_q == ST_ARMED));
  // R3: zero delay is refused at the first press
  assert_zero_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARMED && auth_key_i && wait_zero_i) |=> (err_o && state_q == ST_IDLE));
  // R10: error lasts one cycle
  assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);
  // R8: one write closes the enrollment window
  assert_single_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GRANT && enroll_valid_i) |=> (state_q == ST_IDLE));
  // R6: error always lands in idle
  assert_err_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (state_q == ST_IDLE));
endmodule

// File: rtl/admin_timed_auth.sv
module admin_timed_auth
  import ata_pkg::*;
#(
  parameter int TICK_CYCLES   = 12_500_000,
  parameter int TICKS_PER_SEC = 20,
  parameter int TOL_TICKS     = 10,
  parameter int WAIT_W        = 4,
  parameter int ID_W          = 4,
  parameter int PAT_W         = 4,
  parameter int INTV_W        = 8,
  parameter int NUM_INTV      = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       admin_key,
  input  logic                       auth_key,
  input  logic [WAIT_W-1:0]          wait_sec,
  input  logic                       enroll_valid,
  input  logic [ID_W-1:0]            enroll_id,
  input  logic [PAT_W-1:0]           enroll_pattern,
  input  logic [NUM_INTV*INTV_W-1:0] enroll_intervals,
  output logic                       admin_led,
  output logic                       grant,
  output logic                       err,
  output logic                       wr_en,
  output logic [ID_W-1:0]            wr_id,
  output logic [PAT_W-1:0]           wr_pattern,
  output logic [NUM_INTV*INTV_W-1:0] wr_intervals
);
  localparam int REC_W = NUM_INTV * INTV_W;

  logic       rst_sync_n;
  ata_state_e state;
  logic       start, run, tick, in_window, overrun, fire;

  ata_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ata_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .admin_key_i    (admin_key),
    .auth_key_i     (auth_key),
    .wait_zero_i    (wait_sec == '0),
    .in_window_i    (in_window),
    .overrun_i      (overrun),
    .enroll_valid_i (enroll_valid),
    .state_o        (state),
    .start_o        (start),
    .run_o          (run),
    .err_o          (err),
    .fire_o         (fire)
  );

  ata_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clear_i (start),
    .run_i   (run),
    .tick_o  (tick)
  );

  ata_elapsed #(
    .WAIT_W        (WAIT_W),
    .TICKS_PER_SEC (TICKS_PER_SEC),
    .TOL_TICKS     (TOL_TICKS)
  ) u_elapsed (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .clear_i     (start),
    .run_i       (run),
    .tick_i      (tick),
    .wait_i      (wait_sec),
    .in_window_o (in_window),
    .overrun_o   (overrun)
  );

  ata_enroll_gate #(.ID_W(ID_W), .PAT_W(PAT_W), .REC_W(REC_W)) u_gate (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .fire_i    (fire),
    .id_i      (enroll_id),
    .pat_i     (enroll_pattern),
    .intv_i    (enroll_intervals),
    .wr_en_o   (wr_en),
    .wr_id_o   (wr_id),
    .wr_pat_o  (wr_pattern),
    .wr_intv_o (wr_intervals)
  );

  assign admin_led = (state != ST_IDLE);
  assign grant     = (state == ST_GRANT);

  // R9: a write only follows an open window
  assert_wr_after_grant_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |-> $past(grant));
  // R5: grant never coexists with an error
  assert_grant_no_err_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(grant && err));
endmodule

// File: tb/admin_timed_auth_tb.sv
module admin_timed_auth_tb;
  localparam int T = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        admin_key = 1'b0, auth_key = 1'b0, enroll_valid = 1'b0;
  logic [3:0]  wait_sec = 4'd0, enroll_id = 4'd0, enroll_pattern = 4'd0;
  logic [23:0] enroll_intervals = 24'd0;
  logic        admin_led, grant, err, wr_en;
  logic [3:0]  wr_id, wr_pattern;
  logic [23:0] wr_intervals;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  admin_timed_auth #(.TICK_CYCLES(T)) u_dut (
    .clk(clk), .rst_n(rst_n), .admin_key(admin_key), .auth_key(auth_key),
    .wait_sec(wait_sec), .enroll_valid(enroll_valid), .enroll_id(enroll_id),
    .enroll_pattern(enroll_pattern), .enroll_intervals(enroll_intervals),
    .admin_led(admin_led), .grant(grant), .err(err), .wr_en(wr_en),
    .wr_id(wr_id), .wr_pattern(wr_pattern), .wr_intervals(wr_intervals)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_admin();
    @(negedge clk) admin_key = 1'b1;
    @(negedge clk) admin_key = 1'b0;
  endtask

  // press after k-1 idle cycles, so the sampling edge is k edges after the previous press edge
  task automatic press_auth(input int k);
    repeat (k - 1) @(negedge clk);
    auth_key = 1'b1;
    @(negedge clk) auth_key = 1'b0;
  endtask

  task automatic arm_and_start(input logic [3:0] w);
    pulse_admin();
    wait_sec = w;
    press_auth(1);
  endtask

  task automatic t_reset();
    chk("R1 admin_led", admin_led, 0);
    chk("R1 grant", grant, 0);
    chk("R1 err", err, 0);
    chk("R1 wr_en", wr_en, 0);
  endtask

  task automatic t_ignored_idle();
    wait_sec = 4'd1;
    press_auth(1);
    chk("R11 auth in idle err", err, 0);
    chk("R11 auth in idle led", admin_led, 0);
    @(negedge clk) enroll_valid = 1'b1;
    @(negedge clk) enroll_valid = 1'b0;
    chk("R9 enroll without grant", wr_en, 0);
  endtask

  task automatic t_zero_wait();
    pulse_admin();
    chk("R2 admin_led on", admin_led, 1);
    pulse_admin();
    chk("R11 admin_key in admin", admin_led, 1);
    wait_sec = 4'd0;
    press_auth(1);
    chk("R3 zero wait err", err, 1);
    chk("R3 zero wait idle", admin_led, 0);
    @(negedge clk);
    chk("R10 err one cycle", err, 0);
  endtask

  task automatic t_window(input logic [3:0] w, input int n, input bit pass, input string req);
    arm_and_start(w);
    press_auth(n * T + 1);
    chk({req, " grant"}, grant, pass);
    chk({req, " err"}, err, !pass);
    if (!pass) chk({req, " idle"}, admin_led, 0);
    if (pass) begin
      press_auth(1);
      chk("R11 auth in grant", grant, 1);
      @(negedge clk) enroll_valid = 1'b1;
      @(negedge clk) enroll_valid = 1'b0;
      chk("R8 wr_en", wr_en, 1);
      chk("R8 close", admin_led, 0);
    end
    @(negedge clk);
  endtask

  task automatic t_latched_wait();
    arm_and_start(4'd1);
    wait_sec = 4'd15;
    press_auth(20 * T + 1);
    chk("R12 latched target", grant, 1);
    @(negedge clk) enroll_valid = 1'b1;
    enroll_id = 4'hA; enroll_pattern = 4'b1011; enroll_intervals = 24'h12_34_56;
    @(negedge clk) enroll_valid = 1'b0;
    chk("R8 wr_en", wr_en, 1);
    chk("R8 wr_id", wr_id, 4'hA);
    chk("R8 wr_pattern", wr_pattern, 4'b1011);
    chk("R8 wr_intervals", wr_intervals, 24'h123456);
    chk("R8 grant off", grant, 0);
    enroll_id = 4'h3;
    @(negedge clk);
    chk("R10 wr_en one cycle", wr_en, 0);
    enroll_valid = 1'b1;
    @(negedge clk) enroll_valid = 1'b0;
    chk("R9 second write", wr_en, 0);
    chk("R9 record kept", wr_id, 4'hA);
  endtask

  task automatic t_timeout();
    arm_and_start(4'd1);
    repeat ((20 + 10 + 1) * T) @(negedge clk);
    chk("R7 no early timeout", err, 0);
    chk("R7 still admin", admin_led, 1);
    @(negedge clk);
    chk("R7 timeout err", err, 1);
    chk("R7 timeout idle", admin_led, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ignored_idle();
    t_zero_wait();
    t_window(4'd1, 20, 1'b1, "R5 exact");
    t_window(4'd1, 10, 1'b1, "R5 low edge");
    t_window(4'd1, 30, 1'b1, "R5 high edge");
    t_window(4'd1, 9, 1'b0, "R6 early");
    t_window(4'd1, 31, 1'b0, "R6 late");
    t_window(4'd2, 40, 1'b1, "R4 two sec");
    t_window(4'd2, 29, 1'b0, "R4 two sec short");
    t_latched_wait();
    t_timeout();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule